// File: doc/BRIEF.md
# SPI Memory Access Frame Engine

This block runs one complete SPI transaction against a memory-mapped target. It handles one access chosen by an upstream planner. Each transaction sends a command byte and a 32-bit address. It then either receives read data after a fixed gap or sends write data followed by a closing byte. The data phase is split into words of 2, 4 or 8 bytes. The target is little-endian in memory, but each word goes over the wire most significant byte first, so the engine reverses the byte order inside every word in both directions.

Write bytes come in through a byte stream with a valid/ready handshake. When the caller supplies fewer bytes than the access covers, the missing ones go out as zeros. Read bytes leave on a byte stream as a one-cycle valid strobe per byte, already in memory order. The link runs in SPI mode 0. The serial clock comes from a divider of the system clock.

Top module: `spi_frame_engine`

## Requirements
- R1: After reset, chip select is high, SCLK is low, MOSI is low, and busy, done, wr_ready and rd_valid are all low.
- R2: Each frame opens with a command byte and then the address, most significant byte first. The command byte is 2*kind + 1 for writes and 2*kind for reads: 0x00/0x01 for the 2-byte kind (kind=0), 0x02/0x03 for the 4-byte kind (kind=1), and 0x04/0x05 for burst (kind=2).
- R3: A read frame puts four 0x00 bytes on MOSI after the address, then clocks in len data bytes. The frame is 9+len bytes long.
- R4: A write frame sends the len data bytes right after the address, then one 0x00 byte. The frame is 6+len bytes long.
- R5: The word size W is 2, 4 or 8 bytes for kind 0, 1 or 2. On a write, memory byte j of a word (offset j from the word start) goes out at wire position W-1-j within that word.
- R6: On a read, the bytes of each received word come out on rd_data last-received first. Stream byte w*W+j equals wire data byte w*W+W-1-j.
- R7: Memory offsets at or above src_cnt are sent as 0x00 and use no stream handshake. Exactly min(src_cnt, len) bytes are accepted.
- R8: The link uses SPI mode 0. SCLK idles low, and MOSI changes only while SCLK is low. MISO is sampled on the rising SCLK edge.
- R9: SCLK is high for exactly DIV_HALF system clocks per bit. DIV_HALF = ceil(CLK_HZ / (2*SCLK_HZ)), which must be at least 2.
- R10: Chip select stays low for the whole frame and rises once at its end. done is a single-cycle pulse in the cycle chip select rises.
- R11: A start pulse while busy is ignored. The running frame keeps its address, and no second frame follows.
- R12: len is 2 for kind 0, 4 for kind 1, or a nonzero multiple of 8 no larger than MAX_BURST (240 by default) for burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame with the request fields below (taken when idle) |
| rd_mode | input | 1 | 1 = read frame, 0 = write frame |
| kind | input | 2 | Access kind: 0 = 2-byte, 1 = 4-byte, 2 = burst |
| addr | input | 32 | Target byte address |
| len | input | LEN_W (8) | Data phase length in bytes |
| src_cnt | input | LEN_W (8) | Write bytes the stream will supply; the rest are zero |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| wr_data | input | 8 | Write stream byte, memory order |
| wr_valid | input | 1 | Write stream byte available |
| wr_ready | output | 1 | Engine takes wr_data this cycle when wr_valid is high |
| rd_data | output | 8 | Read stream byte, memory order |
| rd_valid | output | 1 | rd_data valid strobe |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the target |
| spi_miso | input | 1 | Serial data from the target |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs fixed accesses of each kind in both directions and mixes in random accesses. A full 240-byte burst checks the upper length limit. A 2-byte read at an address with distinct bytes in every lane shows whether the address byte order is correct. Target bytes that differ at every wire position show a missing or wrong per-word reversal, and any mix-up between words of size 2, 4 and 8. Writes with src_cnt below len, including an odd count inside a word, show whether zero padding is applied and whether the engine takes too many stream bytes. Random gaps on wr_valid show whether a stalled stream corrupts data. A start pulse fired mid-frame shows whether a busy request leaks into the running frame or starts an extra one.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;

  typedef enum logic [1:0] {
    KIND_HALF  = 2'd0,
    KIND_WORD  = 2'd1,
    KIND_BURST = 2'd2
  } xfer_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_HDR,
    ST_GAP,
    ST_FILL,
    ST_TXD,
    ST_RXD,
    ST_DRAIN,
    ST_TAIL,
    ST_FIN
  } frame_state_e;

  localparam int HDR_BYTES = 5;
  localparam int GAP_BYTES = 4;

  function automatic logic [3:0] word_bytes(input logic [1:0] k);
    case (k)
      KIND_HALF: word_bytes = 4'd2;
      KIND_WORD: word_bytes = 4'd4;
      default:   word_bytes = 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/sfe_bit_shifter.sv
module sfe_bit_shifter #(
  parameter int DIV_HALF = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx_byte,
  output logic       byte_done
);
  localparam int CW = (DIV_HALF > 2) ? $clog2(DIV_HALF) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV_HALF - 1);

  logic          active_q, active_d;
  logic          sclk_q, sclk_d;
  logic [CW-1:0] div_q, div_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          done_q, done_d;

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    div_d    = div_q;
    bit_d    = bit_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (go && !active_q) begin
      active_d = 1'b1;
      tx_d     = tx_byte;
      div_d    = '0;
      bit_d    = 3'd0;
      sclk_d   = 1'b0;
    end else if (active_q) begin
      if (div_q == DIV_LAST) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            active_d = 1'b0;
            done_d   = 1'b1;
          end else begin
            bit_d = bit_q + 3'd1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= 3'd0;
      tx_q     <= 8'h00;
      rx_q     <= 8'h00;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
    end
  end

  assign sclk      = sclk_q;
  assign mosi      = active_q & tx_q[7];
  assign rx_byte   = rx_q;
  assign byte_done = done_q;

  // R8: data line must already be settled when the target samples it
  a_r8_mosi_stable_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_q) |-> $stable(mosi));

endmodule

// File: rtl/sfe_word_buf.sv
module sfe_word_buf (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wr_idx,
  input  logic [7:0] wr_byte,
  input  logic [3:0] wsize,
  input  logic [2:0] rd_idx,
  output logic [7:0] rd_byte
);
  logic [7:0] mem_q [8];
  logic [3:0] mirror;

  for (genvar g = 0; g < 8; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= 8'h00;
      end else if (we && (wr_idx == 3'(g))) begin
        mem_q[g] <= wr_byte;
      end
    end
  end

  // reversed view: position i of the word maps to lane W-1-i
  assign mirror  = wsize - 4'd1 - {1'b0, rd_idx};
  assign rd_byte = mem_q[mirror[2:0]];

endmodule

// File: rtl/sfe_sequencer.sv
module sfe_sequencer
  import spi_frame_pkg::*;
#(
  parameter int LEN_W     = 8,
  parameter int MAX_BURST = 240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_mode,
  input  logic [1:0]       kind,
  input  logic [31:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] src_cnt,
  output logic             busy,
  output logic             done,
  output logic             cs_n,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             sh_go,
  output logic [7:0]       sh_tx,
  input  logic             sh_done,
  input  logic [7:0]       sh_rx,
  output logic             buf_we,
  output logic [2:0]       buf_widx,
  output logic [7:0]       buf_wbyte,
  output logic [3:0]       buf_wsize,
  output logic [2:0]       buf_ridx,
  input  logic [7:0]       buf_rbyte
);
  frame_state_e     st_q, st_d;
  logic [31:0]      addr_q, addr_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [LEN_W-1:0] src_q, src_d;
  logic             rd_q, rd_d;
  logic [1:0]       kind_q, kind_d;
  logic [2:0]       idx_q, idx_d;
  logic [3:0]       wp_q, wp_d;
  logic [LEN_W:0]   off_q, off_d;
  logic             lau_q, lau_d;

  logic [3:0]       wsize;
  logic [LEN_W:0]   off_next;
  logic [LEN_W:0]   mem_pos;
  logic [7:0]       hdr_byte;

  assign wsize    = word_bytes(kind_q);
  assign off_next = off_q + (LEN_W+1)'(wsize);
  assign mem_pos  = off_q + (LEN_W+1)'(wp_q);

  always_comb begin
    case (idx_q)
      3'd0:    hdr_byte = {5'b0, kind_q, ~rd_q};
      3'd1:    hdr_byte = addr_q[31:24];
      3'd2:    hdr_byte = addr_q[23:16];
      3'd3:    hdr_byte = addr_q[15:8];
      default: hdr_byte = addr_q[7:0];
    endcase
  end

  always_comb begin
    st_d      = st_q;
    addr_d    = addr_q;
    len_d     = len_q;
    src_d     = src_q;
    rd_d      = rd_q;
    kind_d    = kind_q;
    idx_d     = idx_q;
    wp_d      = wp_q;
    off_d     = off_q;
    lau_d     = lau_q;
    sh_go     = 1'b0;
    sh_tx     = 8'h00;
    buf_we    = 1'b0;
    buf_widx  = wp_q[2:0];
    buf_wbyte = 8'h00;
    buf_ridx  = wp_q[2:0];
    wr_ready  = 1'b0;
    rd_valid  = 1'b0;
    done      = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          addr_d = addr;
          len_d  = len;
          src_d  = src_cnt;
          rd_d   = rd_mode;
          kind_d = kind;
          idx_d  = 3'd0;
          wp_d   = 4'd0;
          off_d  = '0;
          lau_d  = 1'b0;
          st_d   = ST_HDR;
        end
      end
      ST_HDR: begin
        sh_tx = hdr_byte;
        if (!lau_q) begin
          sh_go = 1'b1;
          lau_d = 1'b1;
        end else if (sh_done) begin
          lau_d = 1'b0;
          if (idx_q == 3'(HDR_BYTES - 1)) begin
            idx_d = 3'd0;
            st_d  = rd_q ? ST_GAP : ST_FILL;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_GAP: begin
        if (!lau_q) begin
          sh_go = 1'b1;
          lau_d = 1'b1;
        end else if (sh_done) begin
          lau_d = 1'b0;
          if (idx_q == 3'(GAP_BYTES - 1)) begin
            idx_d = 3'd0;
            st_d  = ST_RXD;
          end else begin
            idx_d = idx_q + 3'd1;
          end
        end
      end
      ST_FILL: begin
        if (wp_q == wsize) begin
          wp_d = 4'd0;
          st_d = ST_TXD;
        end else if (mem_pos < (LEN_W+1)'(src_q)) begin
          wr_ready = 1'b1;
          if (wr_valid) begin
            buf_we    = 1'b1;
            buf_wbyte = wr_data;
            wp_d      = wp_q + 4'd1;
          end
        end else begin
          buf_we = 1'b1;
          wp_d   = wp_q + 4'd1;
        end
      end
      ST_TXD: begin
        sh_tx = buf_rbyte;
        if (!lau_q) begin
          sh_go = 1'b1;
          lau_d = 1'b1;
        end else if (sh_done) begin
          lau_d = 1'b0;
          if (wp_q == wsize - 4'd1) begin
            wp_d  = 4'd0;
            off_d = off_next;
            st_d  = (off_next == (LEN_W+1)'(len_q)) ? ST_TAIL : ST_FILL;
          end else begin
            wp_d = wp_q + 4'd1;
          end
        end
      end
      ST_RXD: begin
        if (!lau_q) begin
          sh_go = 1'b1;
          lau_d = 1'b1;
        end else if (sh_done) begin
          lau_d     = 1'b0;
          buf_we    = 1'b1;
          buf_wbyte = sh_rx;
          if (wp_q == wsize - 4'd1) begin
            wp_d = 4'd0;
            st_d = ST_DRAIN;
          end else begin
            wp_d = wp_q + 4'd1;
          end
        end
      end
      ST_DRAIN: begin
        rd_valid = 1'b1;
        if (wp_q == wsize - 4'd1) begin
          wp_d  = 4'd0;
          off_d = off_next;
          st_d  = (off_next == (LEN_W+1)'(len_q)) ? ST_FIN : ST_RXD;
        end else begin
          wp_d = wp_q + 4'd1;
        end
      end
      ST_TAIL: begin
        if (!lau_q) begin
          sh_go = 1'b1;
          lau_d = 1'b1;
        end else if (sh_done) begin
          lau_d = 1'b0;
          st_d  = ST_FIN;
        end
      end
      ST_FIN: begin
        done = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= 32'h0;
      len_q  <= '0;
      src_q  <= '0;
      rd_q   <= 1'b0;
      kind_q <= 2'd0;
      idx_q  <= 3'd0;
      wp_q   <= 4'd0;
      off_q  <= '0;
      lau_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      len_q  <= len_d;
      src_q  <= src_d;
      rd_q   <= rd_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
      wp_q   <= wp_d;
      off_q  <= off_d;
      lau_q  <= lau_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign cs_n      = (st_q == ST_IDLE) || (st_q == ST_FIN);
  assign rd_data   = buf_rbyte;
  assign buf_wsize = wsize;

  // R12: caller must present a length that fits the chosen kind
  a_r12_len_fits_kind: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |->
      ((kind == 2'd0 && len == LEN_W'(2)) ||
       (kind == 2'd1 && len == LEN_W'(4)) ||
       (kind == 2'd2 && len != '0 && len[2:0] == 3'b000 && len <= LEN_W'(MAX_BURST))));

  // R10: end-of-frame strobe lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11: a busy engine keeps its latched target address
  a_r11_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(addr_q));

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int SCLK_HZ   = 6_000_000,
  parameter int MAX_BURST = 240,
  localparam int LEN_W    = $clog2(MAX_BURST + 1),
  localparam int DIV_HALF = (CLK_HZ + 2*SCLK_HZ - 1) / (2*SCLK_HZ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             rd_mode,
  input  logic [1:0]       kind,
  input  logic [31:0]      addr,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] src_cnt,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       wr_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             spi_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso,
  output logic             spi_cs_n
);
  logic       sh_go, sh_done;
  logic [7:0] sh_tx, sh_rx;
  logic       buf_we;
  logic [2:0] buf_widx, buf_ridx;
  logic [7:0] buf_wbyte, buf_rbyte;
  logic [3:0] buf_wsize;

  sfe_sequencer #(.LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .kind(kind),
    .addr(addr), .len(len), .src_cnt(src_cnt), .busy(busy), .done(done),
    .cs_n(spi_cs_n), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .sh_go(sh_go), .sh_tx(sh_tx),
    .sh_done(sh_done), .sh_rx(sh_rx), .buf_we(buf_we), .buf_widx(buf_widx),
    .buf_wbyte(buf_wbyte), .buf_wsize(buf_wsize), .buf_ridx(buf_ridx),
    .buf_rbyte(buf_rbyte)
  );

  sfe_bit_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(sh_go), .tx_byte(sh_tx), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(sh_rx), .byte_done(sh_done)
  );

  sfe_word_buf u_buf (
    .clk(clk), .rst_n(rst_n), .we(buf_we), .wr_idx(buf_widx), .wr_byte(buf_wbyte),
    .wsize(buf_wsize), .rd_idx(buf_ridx), .rd_byte(buf_rbyte)
  );

  // R10: serial clock is parked low whenever the target is deselected
  a_r10_sclk_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R7: the write stream is only handshaken mid-frame
  a_r7_ready_inside_frame: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (!spi_cs_n && !rd_valid));

endmodule

// File: tb/test_spi_frame_engine.sv
module test_spi_frame_engine;
  localparam int DIVH = 2;

  logic        clk, rst_n;
  logic        start, rd_mode;
  logic [1:0]  kind;
  logic [31:0] addr;
  logic [7:0]  len, src_cnt;
  logic        busy, done;
  logic [7:0]  wr_data;
  logic        wr_valid, wr_ready;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        sclk, mosi, miso, cs_n;

  spi_frame_engine #(.CLK_HZ(100_000_000), .SCLK_HZ(25_000_000), .MAX_BURST(240)) i_spi_frame_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_mode(rd_mode), .kind(kind),
    .addr(addr), .len(len), .src_cnt(src_cnt), .busy(busy), .done(done),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .spi_sclk(sclk), .spi_mosi(mosi),
    .spi_miso(miso), .spi_cs_n(cs_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit hung  = 1'b0;

  logic [7:0] src [256];
  logic [7:0] cap [300];
  logic [7:0] rdb [256];
  logic [7:0] salt;
  int cap_n, rd_n, ptr, done_n, cs_fall_n, cs_rise_n, bitpos;
  int hi_min, hi_max, hi_run, mosi_bad;
  logic clr, prev_sclk, prev_mosi, prev_cs, stall_en;
  logic [7:0] shreg;

  function automatic logic [7:0] slave_byte(input int p, input logic [7:0] s);
    return 8'((p * 29) + s);
  endfunction

  function automatic int wsz(input logic [1:0] k);
    return (k == 2'd0) ? 2 : (k == 2'd1) ? 4 : 8;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  assign wr_data = src[ptr[7:0]];

  // stream source: consume on handshake
  always @(posedge clk) begin
    if (clr) ptr <= 0;
    else if (wr_valid && wr_ready) ptr <= ptr + 1;
    if (clr) rd_n <= 0;
    else if (rd_valid) begin
      rdb[rd_n[7:0]] <= rd_data;
      rd_n <= rd_n + 1;
    end
  end

  // target model and link monitors, sampled mid-cycle
  always @(negedge clk) begin
    wr_valid <= stall_en ? (($urandom % 4) != 0) : 1'b1;
    if (clr) begin
      cap_n <= 0; done_n <= 0; cs_fall_n <= 0; cs_rise_n <= 0;
      hi_min <= 1000; hi_max <= 0; hi_run <= 0; mosi_bad <= 0;
    end else begin
      if (done) done_n <= done_n + 1;
      if (prev_cs && !cs_n) begin
        cs_fall_n <= cs_fall_n + 1;
        bitpos <= 0;
        miso <= slave_byte(0, salt)[7];
      end
      if (!prev_cs && cs_n) cs_rise_n <= cs_rise_n + 1;
      if (!cs_n && !prev_sclk && sclk) begin
        shreg <= {shreg[6:0], mosi};
        if ((bitpos % 8) == 7) begin
          cap[cap_n] <= {shreg[6:0], mosi};
          cap_n <= cap_n + 1;
        end
        bitpos <= bitpos + 1;
      end
      if (!cs_n && prev_sclk && !sclk)
        miso <= slave_byte(bitpos / 8, salt)[7 - (bitpos % 8)];
      if (sclk) hi_run <= hi_run + 1;
      if (prev_sclk && !sclk) begin
        if (hi_run < hi_min) hi_min <= hi_run;
        if (hi_run > hi_max) hi_max <= hi_run;
        hi_run <= 0;
      end
      if (prev_sclk && sclk && (mosi != prev_mosi)) mosi_bad <= mosi_bad + 1;
    end
    prev_sclk <= sclk;
    prev_mosi <= mosi;
    prev_cs   <= cs_n;
  end

  task automatic run(input logic [1:0] k, input bit rd, input logic [31:0] a,
                     input int n, input int sc, input bit poke);
    int w, waited, exp_len, idx, j, bad_i, bad_a, bad_e;
    if (hung) return;
    w = wsz(k);
    for (int i = 0; i < 256; i++) src[i] = 8'($urandom);
    salt = 8'($urandom);
    @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    kind = k; rd_mode = rd; addr = a; len = 8'(n); src_cnt = 8'(sc); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (40) @(negedge clk);
      addr = ~a; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (done_n == 0 && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    if (done_n == 0) begin
      hung = 1'b1;
      chk(1'b0, "watchdog", waited, 0);
      return;
    end
    repeat (60) @(negedge clk);
    // R2 header
    chk(cap[0] == {5'b0, k, ~rd}, "R2 command byte", cap[0], {5'b0, k, ~rd});
    chk({cap[1], cap[2], cap[3], cap[4]} == a, "R2 address msb first",
        {cap[1], cap[2], cap[3], cap[4]}, a);
    bad_i = -1; bad_a = 0; bad_e = 0;
    if (rd) begin
      exp_len = 9 + n;
      chk(cap_n == exp_len, "R3 read frame length", cap_n, exp_len);
      for (int i = 5; i < 9; i++)
        chk(cap[i] == 8'h00, "R3 gap byte zero", cap[i], 0);
      chk(rd_n == n, "R6 read byte count", rd_n, n);
      for (int i = 0; i < n; i++) begin
        idx = 9 + (i / w) * w + (w - 1 - (i % w));
        if (bad_i < 0 && rdb[i] != slave_byte(idx, salt)) begin
          bad_i = i; bad_a = rdb[i]; bad_e = slave_byte(idx, salt);
        end
      end
      chk(bad_i < 0, "R6 read word reversal", bad_a, bad_e);
      chk(ptr == 0, "R7 read uses no write stream", ptr, 0);
    end else begin
      exp_len = 6 + n;
      chk(cap_n == exp_len, "R4 write frame length", cap_n, exp_len);
      for (int i = 0; i < n; i++) begin
        j = (i / w) * w + (w - 1 - (i % w));
        if (bad_i < 0 && cap[5 + i] != ((j < sc) ? src[j] : 8'h00)) begin
          bad_i = i; bad_a = cap[5 + i]; bad_e = (j < sc) ? src[j] : 0;
        end
      end
      chk(bad_i < 0, "R5 R7 write word reversal and padding", bad_a, bad_e);
      chk(cap[5 + n] == 8'h00, "R4 trailing byte zero", cap[5 + n], 0);
      chk(ptr == ((sc < n) ? sc : n), "R7 stream bytes taken", ptr, (sc < n) ? sc : n);
    end
    chk(hi_min == DIVH && hi_max == DIVH, "R9 sclk high time", hi_max, DIVH);
    chk(mosi_bad == 0, "R8 mosi steady while sclk high", mosi_bad, 0);
    chk(done_n == 1, "R10 single done pulse", done_n, 1);
    chk(cs_fall_n == 1 && cs_rise_n == 1, "R10 R11 one chip-select window", cs_fall_n, 1);
    chk(cs_n == 1'b1 && sclk == 1'b0 && !busy, "R10 idle after frame", cs_n, 1);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; rd_mode = 1'b0; kind = 2'd0; addr = '0;
    len = '0; src_cnt = '0; clr = 1'b0; stall_en = 1'b0; miso = 1'b0;
    salt = 8'h00; shreg = 8'h00; bitpos = 0;
    prev_sclk = 1'b0; prev_mosi = 1'b0; prev_cs = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1 link idle in reset", cs_n, 1);
    chk(!busy && !done && !wr_ready && !rd_valid, "R1 handshakes low in reset", busy, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && !busy && !done, "R1 idle after release", cs_n, 1);

    run(2'd0, 1'b1, 32'h6003_0002, 2, 0, 1'b0);     // 2-byte read
    run(2'd1, 1'b1, 32'h6003_0104, 4, 0, 1'b0);     // 4-byte read
    run(2'd2, 1'b1, 32'h6003_0008, 240, 0, 1'b0);   // longest burst read
    run(2'd0, 1'b0, 32'h5000_0010, 2, 2, 1'b0);     // 2-byte write
    run(2'd1, 1'b0, 32'h5000_0004, 4, 4, 1'b0);     // 4-byte write
    run(2'd0, 1'b0, 32'h5000_0020, 2, 1, 1'b0);     // odd byte padded
    run(2'd2, 1'b0, 32'h5000_0040, 16, 5, 1'b0);    // padding across words
    run(2'd2, 1'b0, 32'h5000_0080, 8, 0, 1'b0);     // all zeros
    stall_en = 1'b1;
    run(2'd2, 1'b0, 32'h5000_0100, 240, 240, 1'b0); // longest burst write, stalls
    run(2'd2, 1'b0, 32'hA5C3_1E78, 24, 24, 1'b1);   // R11 start while busy
    run(2'd1, 1'b1, 32'h1234_5678, 4, 0, 1'b1);     // R11 on a read
    for (int t = 0; t < 10; t++) begin
      logic [1:0] k;
      int n;
      k = 2'($urandom % 3);
      n = (k == 2'd0) ? 2 : (k == 2'd1) ? 4 : 8 * (1 + $urandom % 4);
      run(k, 1'($urandom), $urandom & 32'hFFFF_FFFE, n, $urandom % (n + 1), 1'b0);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule